// File: doc/BRIEF.md
# Transmit Busy Timer

A serial transmitter without a trustworthy "character sent" flag needs some other way to tell software when the next byte may be written. This block supplies that. It monitors the bus write strobe and register address. When software writes the transmit data register, the block raises a busy status bit. That bit stays high for exactly one character frame. Software polls it and writes the next byte only once it reads low.

The frame time comes from two cascaded counters, both running on the crystal clock. A prescaler counts crystal clocks up to a configured divisor, which is crystal frequency divided by baud rate. Each time it reaches the divisor it wraps to zero and emits a one-clock bit tick. A frame counter starts at the configured bits-per-character value and counts down by one on every tick. When it reaches zero the busy bit clears. The divisor and bit count are captured at the moment the write is accepted.

The bus strobe may be asynchronous to the crystal clock, so it passes through a two-stage synchronizer followed by a rising-edge detector. The address must be held stable from one clock before the strobe rises until the strobe falls.

Top module: `txbt_top`

## Requirements
- R1: After reset, `busy_o` is 0 (ready).
- R2: When `wr_strobe_i` rises with `wr_addr_i` equal to 0 (the transmit data register), `busy_o` goes to 1 on the third rising clock edge after the strobe is first high at a clock edge.
- R3: A strobe with any address other than 0 leaves `busy_o` and both counters unchanged.
- R4: `busy_o` stays 1 for exactly D*B clock cycles. D is the captured divisor and B is the captured bit count.
- R5: While busy, the prescaler emits a one-clock bit tick once every D clocks and then wraps to zero. While idle it is held and gives no tick.
- R6: The frame counter loads B at the start pulse and decrements once per tick. When it reaches zero, busy clears in the same cycle as the final tick.
- R7: A strobe held high for many cycles produces only one start. Busy ends after D*B cycles even though the strobe is still high.
- R8: A transmit data write that arrives while busy clears both counters and restarts a full interval, using the configuration present at that write.
- R9: `cfg_div_i` and `cfg_bits_i` are sampled only at the start pulse. Changes made during an interval do not alter its length.
- R10: A divisor of 0 is treated as 1, and a bit count of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_strobe_i | input | 1 | Bus write strobe, may be asynchronous |
| wr_addr_i | input | ADDR_W (2) | Register address of the bus write |
| cfg_div_i | input | DIV_W (12) | Crystal clocks per bit |
| cfg_bits_i | input | BITS_W (4) | Bits per character frame |
| busy_o | output | 1 | 1 = not ready, 0 = ready |

## Verification
The bench measures when busy rises and falls, to the exact cycle, across several divisor and bit-count pairs. A prescaler that is off by one would shift the fall edge by B cycles. A frame counter off by one would shift it by D cycles.

A strobe held high for longer than a whole frame catches level-triggered starts, which would retrigger busy. A second write in mid-frame catches a design that ignores the restart or keeps the old count.

Changing the configuration mid-frame exposes a design that does not capture its inputs at the start. Zero-valued settings catch counters that would wrap around and run for a full counter period. A write to another address must leave the status untouched.

// File: rtl/txbt_pkg.sv
package txbt_pkg;

  typedef enum logic {
    ST_READY = 1'b0,
    ST_BUSY  = 1'b1
  } txbt_status_e;

endpackage

// File: rtl/txbt_start_detect.sv
module txbt_start_detect #(
  parameter int ADDR_W      = 2,
  parameter int TX_ADDR     = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              start_o
);
  localparam int CHAIN = SYNC_STAGES + 1;
  localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(TX_ADDR);

  logic [CHAIN-1:0]  sync_q;
  logic [ADDR_W-1:0] addr_q [SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[CHAIN-2:0], strobe_i};
  end

  // address pipeline kept in step with the strobe synchronizer
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_addr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      addr_q[g] <= '0;
      else if (g == 0) addr_q[g] <= addr_i;
      else             addr_q[g] <= addr_q[g-1];
    end
  end

  assign start_o = sync_q[CHAIN-2] & ~sync_q[CHAIN-1]
                 & (addr_q[SYNC_STAGES-1] == MATCH);
endmodule

// File: rtl/txbt_prescale.sv
module txbt_prescale #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output logic [DIV_W-1:0] cnt_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             at_end;

  assign at_end = (cnt_q >= div_i - DIV_W'(1));
  assign tick_o = en_i & at_end & ~clear_i;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (en_i)    cnt_q <= at_end ? '0 : cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/txbt_frame_cnt.sv
module txbt_frame_cnt #(
  parameter int BITS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [BITS_W-1:0] bits_i,
  input  logic              tick_i,
  output logic              done_o,
  output logic [BITS_W-1:0] cnt_o
);
  logic [BITS_W-1:0] cnt_q;

  assign done_o = tick_i & ~load_i & (cnt_q == BITS_W'(1));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (load_i)                  cnt_q <= bits_i;
    else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - BITS_W'(1);
  end
endmodule

// File: rtl/txbt_top.sv
module txbt_top
  import txbt_pkg::*;
#(
  parameter int ADDR_W  = 2,
  parameter int TX_ADDR = 0,
  parameter int DIV_W   = 12,
  parameter int BITS_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_strobe_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DIV_W-1:0]  cfg_div_i,
  input  logic [BITS_W-1:0] cfg_bits_i,
  output logic              busy_o
);
  logic              start;
  logic              tick;
  logic              done;
  txbt_status_e      state_q;
  logic [DIV_W-1:0]  div_q;
  logic [BITS_W-1:0] bits_q;
  logic [DIV_W-1:0]  div_eff;
  logic [BITS_W-1:0] bits_eff;
  logic [DIV_W-1:0]  pre_cnt;
  logic [BITS_W-1:0] frm_cnt;

  assign div_eff  = (cfg_div_i  == '0) ? DIV_W'(1)  : cfg_div_i;
  assign bits_eff = (cfg_bits_i == '0) ? BITS_W'(1) : cfg_bits_i;

  txbt_start_detect #(.ADDR_W(ADDR_W), .TX_ADDR(TX_ADDR), .SYNC_STAGES(2)) u_start (
    .clk(clk), .rst_n(rst_n), .strobe_i(wr_strobe_i), .addr_i(wr_addr_i),
    .start_o(start)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= DIV_W'(1);
      bits_q <= BITS_W'(1);
    end else if (start) begin
      div_q  <= div_eff;
      bits_q <= bits_eff;
    end
  end

  txbt_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clear_i(start), .en_i(state_q == ST_BUSY),
    .div_i(div_q), .tick_o(tick), .cnt_o(pre_cnt)
  );

  txbt_frame_cnt #(.BITS_W(BITS_W)) u_frm (
    .clk(clk), .rst_n(rst_n), .load_i(start), .bits_i(bits_eff),
    .tick_i(tick), .done_o(done), .cnt_o(frm_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     state_q <= ST_READY;
    else if (start) state_q <= ST_BUSY;
    else if (done)  state_q <= ST_READY;
  end

  assign busy_o = (state_q == ST_BUSY);
endmodule

// File: rtl/txbt_checker.sv
module txbt_checker #(
  parameter int DIV_W  = 12,
  parameter int BITS_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              tick,
  input logic              busy,
  input logic [DIV_W-1:0]  div_q,
  input logic [BITS_W-1:0] bits_q,
  input logic [DIV_W-1:0]  pre_cnt,
  input logic [BITS_W-1:0] frm_cnt
);
  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  // R5
  idle_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tick);
  // R5
  tick_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_q > DIV_W'(1)) |=> !tick);
  // R5
  pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> pre_cnt < div_q);
  // R6
  frame_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (frm_cnt != '0 && frm_cnt <= bits_q));
  // R6
  fall_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(start)) |-> $past(tick));
  // R7
  single_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);
endmodule

bind txbt_top txbt_checker #(.DIV_W(DIV_W), .BITS_W(BITS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .tick(tick), .busy(busy_o),
  .div_q(div_q), .bits_q(bits_q), .pre_cnt(pre_cnt), .frm_cnt(frm_cnt)
);

// File: tb/sim_txbt_top.sv
module sim_txbt_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_strobe = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [11:0] cfg_div = 12'd4;
  logic [3:0]  cfg_bits = 4'd10;
  logic        busy;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  txbt_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_strobe_i(wr_strobe), .wr_addr_i(wr_addr),
    .cfg_div_i(cfg_div), .cfg_bits_i(cfg_bits), .busy_o(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drives a transmit write at a falling edge and measures at which falling
  // edge busy rises and falls. Expect rise at 3 (R2), fall at 3 + D*B (R4, R5, R6).
  task automatic run_frame(input int div, input int bits, input int hold,
                           input int exp_n, input bit change_mid, input string req);
    int rise = 0;
    int fall = 0;
    @(negedge clk);
    cfg_div = 12'(div); cfg_bits = 4'(bits); wr_addr = 2'd0; wr_strobe = 1'b1;
    for (int i = 1; i <= exp_n + hold + 20; i++) begin
      @(negedge clk);
      if (i == hold) wr_strobe = 1'b0;
      if (change_mid && i == 5) begin cfg_div = 12'd9; cfg_bits = 4'd15; end
      if (rise == 0 && busy) rise = i;
      if (rise != 0 && fall == 0 && !busy) fall = i;
    end
    wr_strobe = 1'b0;
    check(rise == 3, {req, " rise"}, rise, 3);
    check(fall == 3 + exp_n, {req, " fall"}, fall, 3 + exp_n);
  endtask

  // R1
  task automatic t_reset;
    check(busy == 1'b0, "R1 reset", int'(busy), 0);
  endtask

  // R3: write to address 1 must leave busy low
  task automatic t_other_addr;
    int seen = 0;
    @(negedge clk);
    wr_addr = 2'd1; wr_strobe = 1'b1;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (i == 3) wr_strobe = 1'b0;
      if (busy) seen++;
    end
    wr_addr = 2'd0;
    check(seen == 0, "R3 other address", seen, 0);
  endtask

  // R8: second write mid-frame restarts full interval
  task automatic t_restart;
    int fall = 0;
    int gaps = 0;
    @(negedge clk);
    cfg_div = 12'd5; cfg_bits = 4'd4; wr_addr = 2'd0; wr_strobe = 1'b1;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      if (i == 2) wr_strobe = 1'b0;
    end
    cfg_div = 12'd2; cfg_bits = 4'd3; wr_strobe = 1'b1;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (i == 2) wr_strobe = 1'b0;
      if (fall == 0 && !busy) begin
        fall = i;
        if (i < 9) gaps++;
      end
    end
    check(fall == 9, "R8 restart fall", fall, 9);
    check(gaps == 0, "R8 no early drop", gaps, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    run_frame(4, 10, 2, 40, 1'b0, "R4 R5 div4 bits10");
    run_frame(96, 10, 2, 960, 1'b0, "R4 R6 div96 bits10");
    run_frame(1, 1, 2, 1, 1'b0, "R5 div1 bits1");
    run_frame(0, 0, 2, 1, 1'b0, "R10 zero config");
    run_frame(3, 2, 30, 6, 1'b0, "R7 held strobe");
    check(busy == 1'b0, "R7 stays ready", int'(busy), 0);
    run_frame(4, 3, 2, 12, 1'b1, "R9 mid-frame config change");
    t_other_addr();
    t_restart();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule